// File: doc/BRIEF.md
# Repeated-Sample Detector with Hold Qualifier

This block watches two single-bit inputs on every rising clock edge and drives one flag. The flag rises once the first input, `a_i`, has shown the same value at two consecutive sampling edges. It stays up while that first input keeps repeating. It also stays up across changes of `a_i`, provided the second input, `b_i`, has been 1 at every edge since the repeat condition last held. Once `b_i` is seen low on an edge where `a_i` does not repeat, the flag drops. It then needs a fresh pair of equal `a_i` samples to rise again.

The machine has five states held in three D flip-flops. There is an idle state, two states that remember a single sample of `a_i`, and two qualified states that also remember the most recent `a_i`. The output is a pure function of the registered state: it is the AND of the two upper state bits. It therefore changes only on clock edges and is free of input-driven glitches. A synchronous active-high reset returns the machine to idle. Any code outside the five legal ones falls back to idle on the next edge.

Top module: `pair_match_fsm`

## Requirements
- R1: An edge with `rst_i`=1 puts the machine in idle, and `z_o` reads 0 after that edge.
- R2: The first `a_i` sample taken after idle never raises `z_o`, whatever `a_i` and `b_i` are.
- R3: When `a_i` has the same value (0 or 1) at two consecutive edges, `z_o` is 1 after the second of them.
- R4: While no repeat has occurred, an `a_i` stream that alternates at every edge keeps `z_o` at 0.
- R5: With `z_o`=1, an edge where `a_i` differs from its previous sample and `b_i`=1 keeps `z_o` at 1.
- R6: With `z_o`=1, an edge where `a_i` differs from its previous sample and `b_i`=0 clears `z_o` to 0.
- R7: With `z_o`=1, an edge where `a_i` equals its previous sample keeps `z_o` at 1, whether `b_i` is 0 or 1.
- R8: `z_o` depends on the registered state only: changes of `a_i` and `b_i` between edges leave it unchanged.
- R9: After `z_o` has been held by `b_i` across a change of `a_i`, the repeat test compares against the newest sample. The next equal `a_i` keeps `z_o` at 1 even with `b_i`=0.
- R10: Over any mixed sequence of inputs and resets, `z_o` after each edge equals the model: last two `a_i` samples equal, or (flag previously 1 and `b_i`=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every input is sampled on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high, forces the idle state |
| a_i | input | 1 | Data input whose repetition is detected |
| b_i | input | 1 | Qualifier that keeps the flag up across changes of `a_i` |
| z_o | output | 1 | Detection flag, decoded from the registered state |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it: the inputs pass through the state register only, and `z_o` is decoded combinationally from it. The bench changes `a_i` and `b_i` 2 ns after an edge and reads `z_o` 2 ns after the following edge, so each check sees the state produced by exactly one sampled input pair. For R8 the inputs are toggled several times inside one period and `z_o` is read between the toggles, before the next edge arrives.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

    localparam int STATE_W = 3;

    // Upper bit: at least one sample taken; middle bit: qualified;
    // lowest bit: most recent value of a_i.
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 3'b000,
        ST_SEEN0  = 3'b100,
        ST_SEEN1  = 3'b101,
        ST_MATCH0 = 3'b110,
        ST_MATCH1 = 3'b111
    } pmf_state_e;

    typedef struct packed {
        pmf_state_e state;
    } pmf_regs_t;

endpackage

// File: rtl/pmf_next.sv
module pmf_next
    import pmf_pkg::*;
(
    input  pmf_state_e cur_i,
    input  logic       a_i,
    input  logic       b_i,
    output pmf_state_e nxt_o
);
    always_comb begin
        unique case (cur_i)
            ST_IDLE:   nxt_o = a_i ? ST_SEEN1 : ST_SEEN0;
            ST_SEEN0:  nxt_o = a_i ? ST_SEEN1 : ST_MATCH0;
            ST_SEEN1:  nxt_o = a_i ? ST_MATCH1 : ST_SEEN0;
            ST_MATCH0: begin
                if (!a_i)     nxt_o = ST_MATCH0;
                else if (b_i) nxt_o = ST_MATCH1;
                else          nxt_o = ST_SEEN1;
            end
            ST_MATCH1: begin
                if (a_i)      nxt_o = ST_MATCH1;
                else if (b_i) nxt_o = ST_MATCH0;
                else          nxt_o = ST_SEEN0;
            end
            default:   nxt_o = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/pmf_out.sv
module pmf_out (
    input  logic [1:0] upper_i,
    output logic       z_o
);
    always_comb z_o = upper_i[1] & upper_i[0];
endmodule

// File: rtl/pair_match_fsm.sv
module pair_match_fsm
    import pmf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic a_i,
    input  logic b_i,
    output logic z_o
);
    pmf_regs_t  regs_d, regs_q;
    pmf_state_e step_state;

    pmf_next u_next (
        .cur_i (regs_q.state),
        .a_i   (a_i),
        .b_i   (b_i),
        .nxt_o (step_state)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst_i) regs_d.state = ST_IDLE;
        else       regs_d.state = step_state;
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    pmf_out u_out (
        .upper_i (regs_q.state[STATE_W-1:STATE_W-2]),
        .z_o     (z_o)
    );

    // R1: a reset edge leaves the flag low
    assert_reset_clears_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !z_o);

    // R1: only legal codes are reached after reset
    assert_legal_state_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (regs_q.state inside {ST_IDLE, ST_SEEN0, ST_SEEN1, ST_MATCH0, ST_MATCH1}));

    // R2: first sample out of idle never raises the flag
    assert_first_sample_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.state == ST_IDLE) |=> !z_o);

    // R3: a repeated sample after a seen state raises the flag
    assert_repeat_sets_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.state[2] && (a_i == regs_q.state[0])) |=> z_o);

    // R5: flag held across a change while b_i is high
    assert_hold_by_b_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (z_o && (a_i != regs_q.state[0]) && b_i) |=> z_o);

    // R6: flag dropped on a change while b_i is low
    assert_drop_no_b_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (z_o && (a_i != regs_q.state[0]) && !b_i) |=> !z_o);
endmodule

// File: tb/pair_match_fsm_test.sv
module pair_match_fsm_test;
    localparam time CYC = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a   = 1'b0;
    logic b   = 1'b0;
    logic z;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // reference model state
    bit m_have = 1'b0;
    bit m_last = 1'b0;
    bit m_ok   = 1'b0;

    always #(CYC/2) clk = ~clk;

    pair_match_fsm uut (
        .clk_i (clk),
        .rst_i (rst),
        .a_i   (a),
        .b_i   (b),
        .z_o   (z)
    );

    task automatic check(input bit exp, input string req, input string what);
        total++;
        if (z !== exp) begin
            bad++;
            $display("FAIL %s %s: z actual=%b expected=%b", req, what, z, exp);
        end
    endtask

    // drive inputs, take one edge, update model, land 2 ns after the edge
    task automatic step(input bit na, input bit nb, input bit nr = 1'b0);
        a = na; b = nb; rst = nr;
        @(posedge clk);
        if (nr) begin
            m_have = 1'b0; m_ok = 1'b0;
        end else begin
            m_ok   = (m_have && (na == m_last)) || (m_ok && nb);
            m_have = 1'b1;
            m_last = na;
        end
        #2ns;
        rst = 1'b0;
    endtask

    task automatic t_reset;
        step(1'b1, 1'b1, 1'b1);
        check(1'b0, "R1", "after reset edge");
        step(1'b1, 1'b1); step(1'b1, 1'b1);
        check(1'b1, "R3", "pair of ones before reset");
        step(1'b1, 1'b1, 1'b1);
        check(1'b0, "R1", "reset from qualified state");
    endtask

    task automatic t_first_sample;
        step(1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b1);
        check(1'b0, "R2", "first sample a=1 b=1");
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1);
        check(1'b0, "R2", "first sample a=0 b=1");
    endtask

    task automatic t_pairs;
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        check(1'b1, "R3", "two zeros");
        step(1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        check(1'b1, "R3", "two ones");
    endtask

    task automatic t_alternate;
        step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) begin
            step(i[0], 1'b1);
            check(1'b0, "R4", "alternating a");
        end
    endtask

    task automatic t_hold_and_drop;
        step(1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check(1'b1, "R5", "change 1->0 with b=1");
        step(1'b1, 1'b1);
        check(1'b1, "R5", "change 0->1 with b=1");
        step(1'b0, 1'b0);
        check(1'b0, "R6", "change 1->0 with b=0");
        step(1'b1, 1'b1);
        check(1'b0, "R6", "b=1 after drop needs new pair");
    endtask

    task automatic t_equal_ignores_b;
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1); step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        check(1'b1, "R7", "repeat zero b=0");
        step(1'b0, 1'b1);
        check(1'b1, "R7", "repeat zero b=1");
    endtask

    task automatic t_mid_cycle;
        step(1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            a = i[0]; b = i[1];
            #1ns;
            check(1'b1, "R8", "mid-cycle toggle while high");
        end
        step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            a = ~i[0]; b = ~i[1];
            #1ns;
            check(1'b0, "R8", "mid-cycle toggle while low");
        end
    endtask

    task automatic t_refresh;
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        check(1'b1, "R9", "held by b across change");
        step(1'b1, 1'b0);
        check(1'b1, "R9", "newest sample repeated with b=0");
        step(1'b0, 1'b0);
        check(1'b0, "R9", "then change with b=0 drops");
    endtask

    task automatic t_random;
        step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 2000; i++) begin
            int unsigned r = $urandom;
            step(r[0], r[1] | r[2], (r[9:4] == 6'd0));
            check(m_ok, "R10", "random sequence vs model");
        end
    endtask

    initial begin
        #(CYC * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        #2ns;
        t_reset();
        t_first_sample();
        t_pairs();
        t_alternate();
        t_hold_and_drop();
        t_equal_ignores_b();
        t_mid_cycle();
        t_refresh();
        t_random();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule